// File: doc/BRIEF.md
# Burst-Four Quad-Data-Rate SRAM Command Sequencer

This block sits between user logic and a quad-data-rate SRAM whose every access moves a burst of four words. User logic sends read and write requests on two independent valid/ready channels. The sequencer puts them on the memory's single shared address bus, at most one command per controller cycle. Each memory clock cycle carries two data beats: one for the rising K edge and one for the K-complement edge. The block therefore presents write data and returned read data as rise/fall word pairs. The selects on the memory side are active-high here; inverting them for an active-low device is left to the physical layer.

A write request carries all four words and one byte-enable mask per word. The sequencer issues the write command and then drives the data as two beat pairs in the two cycles that follow. A read command causes the memory to return two beat pairs after a fixed latency of `RD_LAT` cycles. The sequencer assembles these into one four-word response with a single valid strobe, in the order the reads were issued. Each burst takes two memory cycles, and a command of the same kind issued inside that window would be dropped by the memory. The sequencer therefore holds each channel off for one cycle after every grant. When both channels are eligible at once, a round-robin pointer decides which one is granted.

Top module: `qdrb4_ctrl`

## Requirements
- R1: After reset, `mem_rsel`, `mem_wsel`, `mem_wd_en` and `rsp_valid` are 0, and with no requests pending both `rd_ready` and `wr_ready` are 1.
- R2: A write accepted at a clock edge (`wr_valid` and `wr_ready` high) puts `mem_wsel`=1 on the memory in the very next cycle, with `mem_addr` equal to the accepted `wr_addr`.
- R3: In the cycle after a write command, `mem_wd_en`=1 and `mem_wd_rise`/`mem_wd_fall` carry words 0 and 1 (`wr_data` bits [DW-1:0] and [2DW-1:DW]). In the cycle after that, `mem_wd_en`=1 and they carry words 2 and 3. In every other cycle `mem_wd_en`, the data and the byte enables are all 0.
- R4: A read accepted at a clock edge puts `mem_rsel`=1 on the memory in the next cycle, with `mem_addr` equal to the accepted `rd_addr`.
- R5: For a read command in cycle C, the pair on `mem_rd_rise`/`mem_rd_fall` in cycle C+RD_LAT becomes words 0/1 and the pair in cycle C+RD_LAT+1 becomes words 2/3. `rsp_valid` is 1 for exactly cycle C+RD_LAT+2, with word k at `rsp_data` bits [k*DW +: DW]. Read-data values in any other cycle are ignored.
- R6: Two commands of the same kind are never on the bus in consecutive cycles. In the cycle right after a grant, that channel's ready is 0.
- R7: `mem_rsel` and `mem_wsel` are never 1 in the same cycle, and at most one request is accepted per edge.
- R8: When both channels are valid and eligible in the same cycle, the grant goes to the kind that was not granted last. After reset, the first tie goes to the read.
- R9: Byte-enable bit i of a beat covers data lanes [9i+8:9i]. Mask k (`wr_be` bits [k*LANES +: LANES]) is driven on `mem_be_rise` (k even) or `mem_be_fall` (k odd) in the same cycle as word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one cycle per memory K cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | AW | Read burst address |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be accepted |
| wr_addr | input | AW | Write burst address |
| wr_data | input | 4*DW | Four write words, word 0 in the low bits |
| wr_be | input | 4*LANES | Four byte-enable masks, mask 0 in the low bits |
| rsp_valid | output | 1 | Read response strobe, one cycle per burst |
| rsp_data | output | 4*DW | Four read words, word 0 in the low bits |
| mem_rsel | output | 1 | Read command to memory (active high) |
| mem_wsel | output | 1 | Write command to memory (active high) |
| mem_addr | output | AW | Shared command address |
| mem_wd_en | output | 1 | Write data window qualifier |
| mem_wd_rise | output | DW | Write word for the K rising edge |
| mem_wd_fall | output | DW | Write word for the K-complement edge |
| mem_be_rise | output | LANES | Byte enables for the rising-edge word |
| mem_be_fall | output | LANES | Byte enables for the falling-edge word |
| mem_rd_rise | input | DW | Returned read word from the rising edge |
| mem_rd_fall | input | DW | Returned read word from the falling edge |

## Verification
The bench runs reads and writes back to back and then concurrently. This exposes a sequencer that reissues a command inside the burst window, which would make the memory drop a whole burst, or one that puts both selects on the shared bus in one cycle. It checks the write beats in the exact two cycles after the command. Data shifted by a cycle, or a swapped word pair, shows up as wrong words or wrong enables, and data leaking outside the window shows up as a nonzero qualifier. The read model drives garbage outside the two return cycles, so a capture taken one cycle off yields corrupted responses. Two simultaneous-request cases, one after a lone read and one after a lone write, catch an arbiter that always favours one side.

// File: rtl/qdrb4_pkg.sv
package qdrb4_pkg;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned LANE_BITS   = 9;
  localparam int unsigned BEATS_PER_K = 2;

  typedef enum logic {
    PICK_RD = 1'b0,
    PICK_WR = 1'b1
  } pick_e;
endpackage

// File: rtl/qdrb4_arbiter.sv
module qdrb4_arbiter
  import qdrb4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic wr_valid,
  output logic rd_ready,
  output logic wr_ready,
  output logic rd_grant,
  output logic wr_grant
);
  // a channel that was granted last cycle is still inside its burst window
  logic  rd_busy_q, wr_busy_q;
  pick_e next_q;
  logic  rd_elig, wr_elig;

  assign rd_elig  = !rd_busy_q;
  assign wr_elig  = !wr_busy_q;
  assign rd_ready = rd_elig && !(wr_valid && wr_elig && (next_q == PICK_WR));
  assign wr_ready = wr_elig && !(rd_valid && rd_elig && (next_q == PICK_RD));
  assign rd_grant = rd_valid && rd_ready;
  assign wr_grant = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy_q <= 1'b0;
      wr_busy_q <= 1'b0;
      next_q    <= PICK_RD;
    end else begin
      rd_busy_q <= rd_grant;
      wr_busy_q <= wr_grant;
      if (rd_grant)      next_q <= PICK_WR;
      else if (wr_grant) next_q <= PICK_RD;
    end
  end
endmodule

// File: rtl/qdrb4_wr_seq.sv
module qdrb4_wr_seq
  import qdrb4_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * LANE_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         grant,
  input  logic [AW-1:0]                addr,
  input  logic [BURST_BEATS*DW-1:0]    data,
  input  logic [BURST_BEATS*LANES-1:0] be,
  output logic                         wsel,
  output logic [AW-1:0]                waddr,
  output logic                         wd_en,
  output logic [DW-1:0]                wd_rise,
  output logic [DW-1:0]                wd_fall,
  output logic [LANES-1:0]             be_rise,
  output logic [LANES-1:0]             be_fall
);
  logic [BURST_BEATS*DW-1:0]    buf_data_q;
  logic [BURST_BEATS*LANES-1:0] buf_be_q;
  logic                         second_half_q;

  function automatic logic [DW-1:0] word_of(input logic [BURST_BEATS*DW-1:0] b,
                                            input int unsigned k);
    return b[k*DW +: DW];
  endfunction

  function automatic logic [LANES-1:0] mask_of(input logic [BURST_BEATS*LANES-1:0] m,
                                               input int unsigned k);
    return m[k*LANES +: LANES];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel          <= 1'b0;
      waddr         <= '0;
      buf_data_q    <= '0;
      buf_be_q      <= '0;
      second_half_q <= 1'b0;
      wd_en         <= 1'b0;
      wd_rise       <= '0;
      wd_fall       <= '0;
      be_rise       <= '0;
      be_fall       <= '0;
    end else begin
      wsel          <= grant;
      second_half_q <= wsel;
      if (grant) begin
        waddr      <= addr;
        buf_data_q <= data;
        buf_be_q   <= be;
      end
      if (wsel) begin
        wd_en   <= 1'b1;
        wd_rise <= word_of(buf_data_q, 0);
        wd_fall <= word_of(buf_data_q, 1);
        be_rise <= mask_of(buf_be_q, 0);
        be_fall <= mask_of(buf_be_q, 1);
      end else if (second_half_q) begin
        wd_en   <= 1'b1;
        wd_rise <= word_of(buf_data_q, 2);
        wd_fall <= word_of(buf_data_q, 3);
        be_rise <= mask_of(buf_be_q, 2);
        be_fall <= mask_of(buf_be_q, 3);
      end else begin
        wd_en   <= 1'b0;
        wd_rise <= '0;
        wd_fall <= '0;
        be_rise <= '0;
        be_fall <= '0;
      end
    end
  end
endmodule

// File: rtl/qdrb4_rd_cap.sv
module qdrb4_rd_cap
  import qdrb4_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned DW    = LANES * LANE_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grant,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             rd_rise,
  input  logic [DW-1:0]             rd_fall,
  output logic                      rsel,
  output logic [AW-1:0]             raddr,
  output logic                      head_hit,
  output logic                      tail_hit,
  output logic                      rsp_valid,
  output logic [BURST_BEATS*DW-1:0] rsp_data
);
  // bit k set: a read command was on the bus k+1 cycles ago
  logic [RD_LAT:0]            age_q;
  logic [BEATS_PER_K*DW-1:0]  head_q;

  assign head_hit = age_q[RD_LAT-1];
  assign tail_hit = age_q[RD_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel      <= 1'b0;
      raddr     <= '0;
      age_q     <= '0;
      head_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsel  <= grant;
      if (grant) raddr <= addr;
      age_q <= {age_q[RD_LAT-1:0], rsel};
      if (head_hit) head_q <= {rd_fall, rd_rise};
      rsp_valid <= tail_hit;
      if (tail_hit) rsp_data <= {rd_fall, rd_rise, head_q};
    end
  end
endmodule

// File: rtl/qdrb4_ctrl.sv
module qdrb4_ctrl
  import qdrb4_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned DW    = LANES * LANE_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_valid,
  output logic                         rd_ready,
  input  logic [AW-1:0]                rd_addr,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BURST_BEATS*DW-1:0]    wr_data,
  input  logic [BURST_BEATS*LANES-1:0] wr_be,
  output logic                         rsp_valid,
  output logic [BURST_BEATS*DW-1:0]    rsp_data,
  output logic                         mem_rsel,
  output logic                         mem_wsel,
  output logic [AW-1:0]                mem_addr,
  output logic                         mem_wd_en,
  output logic [DW-1:0]                mem_wd_rise,
  output logic [DW-1:0]                mem_wd_fall,
  output logic [LANES-1:0]             mem_be_rise,
  output logic [LANES-1:0]             mem_be_fall,
  input  logic [DW-1:0]                mem_rd_rise,
  input  logic [DW-1:0]                mem_rd_fall
);
  logic          rd_grant, wr_grant;
  logic          rd_head_hit, rd_tail_hit;
  logic [AW-1:0] rd_cmd_addr, wr_cmd_addr;

  qdrb4_arbiter arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .wr_valid (wr_valid),
    .rd_ready (rd_ready),
    .wr_ready (wr_ready),
    .rd_grant (rd_grant),
    .wr_grant (wr_grant)
  );

  qdrb4_wr_seq #(.AW(AW), .LANES(LANES)) wr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (wr_grant),
    .addr    (wr_addr),
    .data    (wr_data),
    .be      (wr_be),
    .wsel    (mem_wsel),
    .waddr   (wr_cmd_addr),
    .wd_en   (mem_wd_en),
    .wd_rise (mem_wd_rise),
    .wd_fall (mem_wd_fall),
    .be_rise (mem_be_rise),
    .be_fall (mem_be_fall)
  );

  qdrb4_rd_cap #(.AW(AW), .LANES(LANES), .RD_LAT(RD_LAT)) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (rd_grant),
    .addr      (rd_addr),
    .rd_rise   (mem_rd_rise),
    .rd_fall   (mem_rd_fall),
    .rsel      (mem_rsel),
    .raddr     (rd_cmd_addr),
    .head_hit  (rd_head_hit),
    .tail_hit  (rd_tail_hit),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // shared bus: the arbiter guarantees only one path holds a command per cycle
  assign mem_addr = mem_rsel ? rd_cmd_addr : wr_cmd_addr;
endmodule

// File: rtl/qdrb4_ctrl_chk.sv
module qdrb4_ctrl_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic          mem_rsel,
  input logic          mem_wsel,
  input logic [AW-1:0] mem_addr,
  input logic          mem_wd_en,
  input logic          rsp_valid,
  input logic          rd_head_hit,
  input logic          rd_tail_hit
);
  a_r2_wr_cmd_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (mem_wsel && mem_addr == $past(wr_addr)));
  a_r4_rd_cmd_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (mem_rsel && mem_addr == $past(rd_addr)));
  a_r3_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wsel |=> mem_wd_en);
  a_r3_data_source: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_en |-> ($past(mem_wsel) || $past(mem_wsel, 2)));
  a_r6_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wsel |=> !mem_wsel);
  a_r6_rd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsel |=> !mem_rsel);
  a_r7_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rsel && mem_wsel));
  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready && wr_valid && wr_ready));
  a_r5_rsp_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_tail_hit));
  a_r5_tail_after_head: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tail_hit |-> $past(rd_head_hit));
endmodule

bind qdrb4_ctrl qdrb4_ctrl_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_addr     (rd_addr),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .mem_rsel    (mem_rsel),
  .mem_wsel    (mem_wsel),
  .mem_addr    (mem_addr),
  .mem_wd_en   (mem_wd_en),
  .rsp_valid   (rsp_valid),
  .rd_head_hit (rd_head_hit),
  .rd_tail_hit (rd_tail_hit)
);

// File: tb/qdrb4_ctrl_tb_top.sv
module qdrb4_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 8;
  localparam int LANES  = 2;
  localparam int RD_LAT = 2;
  localparam int DW     = LANES * 9;
  localparam int BW     = 4 * DW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_valid = 1'b0, wr_valid = 1'b0;
  logic            rd_ready, wr_ready;
  logic [AW-1:0]   rd_addr = '0, wr_addr = '0;
  logic [BW-1:0]   wr_data = '0;
  logic [4*LANES-1:0] wr_be = '0;
  logic            rsp_valid;
  logic [BW-1:0]   rsp_data;
  logic            mem_rsel, mem_wsel, mem_wd_en;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wd_rise, mem_wd_fall, mem_rd_rise = '0, mem_rd_fall = '0;
  logic [LANES-1:0] mem_be_rise, mem_be_fall;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdrb4_ctrl #(.AW(AW), .LANES(LANES), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_rsel(mem_rsel), .mem_wsel(mem_wsel), .mem_addr(mem_addr),
    .mem_wd_en(mem_wd_en), .mem_wd_rise(mem_wd_rise), .mem_wd_fall(mem_wd_fall),
    .mem_be_rise(mem_be_rise), .mem_be_fall(mem_be_fall),
    .mem_rd_rise(mem_rd_rise), .mem_rd_fall(mem_rd_fall)
  );

  typedef struct {
    logic [AW-1:0]      addr;
    logic [BW-1:0]      data;
    logic [4*LANES-1:0] be;
  } wr_item_t;

  typedef struct {
    logic [BW-1:0] data;
    int            due;
  } rsp_item_t;

  int n_chk = 0, n_fail = 0, cyc = 0, ncmd = 0;
  bit done = 1'b0;
  logic [AW-1:0] rcmd_q[$];
  wr_item_t      wcmd_q[$];
  rsp_item_t     rsp_q[$];
  byte           cmd_kind[0:255];
  bit            hist_rsel[0:15];
  logic [AW-1:0] hist_addr[0:15];

  function automatic logic [DW-1:0] rword(input logic [AW-1:0] a, input int k);
    logic [1:0] kb;
    kb = 2'(k);
    return DW'({kb, a, ~a});
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send_rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = a;
    #1;
    while (!rd_ready) begin
      @(negedge clk);
      #1;
    end
    rcmd_q.push_back(a);
    @(posedge clk);
    #1;
    rd_valid = 1'b0;
    check(rd_ready == 1'b0, "R6 rd_ready low after grant", BW'(rd_ready), '0);
  endtask

  task automatic send_wr(input logic [AW-1:0] a, input logic [BW-1:0] d,
                         input logic [4*LANES-1:0] m);
    wr_item_t it;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    wr_be    = m;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    it.addr = a; it.data = d; it.be = m;
    wcmd_q.push_back(it);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    check(wr_ready == 1'b0, "R6 wr_ready low after grant", BW'(wr_ready), '0);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: memory model, write-beat checks, response scoreboard
  wr_item_t s1, s2;
  bit s1_v = 1'b0, s2_v = 1'b0;
  logic prev_rsel = 1'b0, prev_wsel = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      // R3/R9: write beats expected in this cycle
      if (s1_v) begin
        check(mem_wd_en && mem_wd_rise == s1.data[0 +: DW] && mem_wd_fall == s1.data[DW +: DW],
              "R3 beats 0/1", BW'({mem_wd_en, mem_wd_fall, mem_wd_rise}),
              BW'({1'b1, s1.data[DW +: DW], s1.data[0 +: DW]}));
        check(mem_be_rise == s1.be[0 +: LANES] && mem_be_fall == s1.be[LANES +: LANES],
              "R9 masks 0/1", BW'({mem_be_fall, mem_be_rise}), BW'(s1.be[0 +: 2*LANES]));
      end else if (s2_v) begin
        check(mem_wd_en && mem_wd_rise == s2.data[2*DW +: DW] && mem_wd_fall == s2.data[3*DW +: DW],
              "R3 beats 2/3", BW'({mem_wd_en, mem_wd_fall, mem_wd_rise}),
              BW'({1'b1, s2.data[3*DW +: DW], s2.data[2*DW +: DW]}));
        check(mem_be_rise == s2.be[2*LANES +: LANES] && mem_be_fall == s2.be[3*LANES +: LANES],
              "R9 masks 2/3", BW'({mem_be_fall, mem_be_rise}), BW'(s2.be[2*LANES +: 2*LANES]));
      end else if (mem_wd_en || mem_wd_rise != '0 || mem_be_rise != '0 || mem_be_fall != '0) begin
        check(1'b0, "R3 write data outside window", BW'({mem_wd_en, mem_wd_rise}), '0);
      end
      s2 = s1; s2_v = s1_v; s1_v = 1'b0;
      // commands
      if (mem_rsel || mem_wsel)
        check(!(mem_rsel && mem_wsel), "R7 single command", BW'({mem_rsel, mem_wsel}), 'b10);
      hist_rsel[cyc & 15] = 1'b0;
      if (mem_rsel) begin
        logic [AW-1:0] a;
        rsp_item_t r;
        check(!prev_rsel, "R6 read spacing", BW'(prev_rsel), '0);
        a = (rcmd_q.size() != 0) ? rcmd_q.pop_front() : '0;
        check(mem_addr == a, "R4 read address", BW'(mem_addr), BW'(a));
        hist_rsel[cyc & 15] = 1'b1;
        hist_addr[cyc & 15] = mem_addr;
        r.data = {rword(a, 3), rword(a, 2), rword(a, 1), rword(a, 0)};
        r.due  = cyc + RD_LAT + 2;
        rsp_q.push_back(r);
        cmd_kind[ncmd & 255] = "R";
        ncmd++;
      end
      if (mem_wsel && !mem_rsel) begin
        wr_item_t w;
        check(!prev_wsel, "R6 write spacing", BW'(prev_wsel), '0);
        if (wcmd_q.size() != 0) w = wcmd_q.pop_front();
        check(mem_addr == w.addr, "R2 write address", BW'(mem_addr), BW'(w.addr));
        s1 = w; s1_v = 1'b1;
        cmd_kind[ncmd & 255] = "W";
        ncmd++;
      end
      prev_rsel = mem_rsel;
      prev_wsel = mem_wsel;
      // R5: memory model drives the pair for this cycle, garbage otherwise
      if (hist_rsel[(cyc - RD_LAT) & 15]) begin
        mem_rd_rise = rword(hist_addr[(cyc - RD_LAT) & 15], 0);
        mem_rd_fall = rword(hist_addr[(cyc - RD_LAT) & 15], 1);
      end else if (hist_rsel[(cyc - RD_LAT - 1) & 15]) begin
        mem_rd_rise = rword(hist_addr[(cyc - RD_LAT - 1) & 15], 2);
        mem_rd_fall = rword(hist_addr[(cyc - RD_LAT - 1) & 15], 3);
      end else begin
        mem_rd_rise = DW'(cyc * 7 + 5);
        mem_rd_fall = DW'(cyc * 13 + 1);
      end
      // response scoreboard
      if (rsp_valid) begin
        rsp_item_t e;
        if (rsp_q.size() != 0) begin
          e = rsp_q.pop_front();
          check(rsp_data == e.data, "R5 response data", rsp_data, e.data);
          check(cyc == e.due, "R5 response cycle", BW'(cyc), BW'(e.due));
        end else begin
          check(1'b0, "R5 unexpected response", rsp_data, '0);
        end
      end else if (rsp_q.size() != 0 && rsp_q[0].due == cyc) begin
        check(1'b0, "R5 missing response", '0, rsp_q[0].data);
        void'(rsp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!mem_rsel && !mem_wsel && !mem_wd_en && !rsp_valid, "R1 outputs idle",
          BW'({mem_rsel, mem_wsel, mem_wd_en, rsp_valid}), '0);
    check(rd_ready && wr_ready, "R1 both ready", BW'({rd_ready, wr_ready}), 'b11);

    // R8: first tie after reset goes to the read
    n0 = ncmd;
    fork
      send_rd(8'h11);
      send_wr(8'h22, {4{18'h2A5A5}}, 8'hFF);
    join
    repeat (6) @(negedge clk);
    check(cmd_kind[n0 & 255] == "R", "R8 first tie to read", BW'(cmd_kind[n0 & 255]), BW'("R"));

    // R2/R3/R9: lone writes with sparse masks
    send_wr(8'h40, {18'h3FFFF, 18'h00001, 18'h15555, 18'h2AAAA}, 8'b10_01_00_11);
    repeat (5) @(negedge clk);
    send_wr(8'h41, {18'h12345, 18'h23456, 18'h34567, 18'h01234}, 8'b01_10_11_00);
    repeat (5) @(negedge clk);

    // R8: after a lone write, a tie goes to the read
    n0 = ncmd;
    fork
      send_rd(8'h33);
      send_wr(8'h44, {4{18'h0F0F0}}, 8'h5A);
    join
    repeat (6) @(negedge clk);
    check(cmd_kind[n0 & 255] == "R", "R8 tie after write", BW'(cmd_kind[n0 & 255]), BW'("R"));

    // lone read, then a tie must go to the write
    send_rd(8'h55);
    repeat (6) @(negedge clk);
    n0 = ncmd;
    fork
      send_rd(8'h66);
      send_wr(8'h77, {4{18'h1E1E1}}, 8'hA5);
    join
    repeat (6) @(negedge clk);
    check(cmd_kind[n0 & 255] == "W", "R8 tie after read", BW'(cmd_kind[n0 & 255]), BW'("W"));

    // R6: back-to-back reads, then back-to-back writes
    for (int i = 0; i < 5; i++) send_rd(8'h80 + 8'(i));
    for (int i = 0; i < 5; i++) send_wr(8'h90 + 8'(i), {4{18'(i * 999 + 3)}}, 8'(i * 37 + 1));
    repeat (6) @(negedge clk);

    // R7: both channels streaming together
    fork
      for (int i = 0; i < 6; i++) send_rd(8'hA0 + 8'(i));
      for (int i = 0; i < 6; i++) send_wr(8'hB0 + 8'(i), {18'(i), 18'(i + 100), 18'(i + 200), 18'(i + 300)}, 8'(8'hC3 ^ 8'(i)));
    join
    repeat (12) @(negedge clk);
    check(rsp_q.size() == 0 && rcmd_q.size() == 0, "R5 all reads answered",
          BW'(rsp_q.size()), '0);
    check(wcmd_q.size() == 0, "R2 all writes issued", BW'(wcmd_q.size()), '0);
    finish_run();
  end
endmodule